// File: doc/BRIEF.md
# Four-Channel Transceiver Management Register Bank

This block holds the control and identification registers of a four-channel serial transceiver. Requests come in over a parallel management bus: a valid strobe, a write flag, a 5-bit device address, a 5-bit register address and 16 bits of write data. The block answers on four consecutive device addresses, one per channel. The upper three address bits must match a strap input, and the lower two bits select the channel.

Each channel has its own rate, comma-alignment, loopback and loss-of-signal configuration. These drive per-channel control outputs. A small group of shared registers is reached only through channel 0: two fixed identification words and a 9-bit error-code register that feeds every channel. Internal loopback can be reached at two register locations, and both locations refer to the same storage bit.

Every request finishes in one clock. The response (acknowledge plus read data) is registered and appears in the cycle after the request.

Top module: `mgmt_regbank`

## Requirements
- R1: A request is acknowledged (rsp_ack_o high for one cycle) only when req_devad_i[4:2] equals strap_i. The channel is then req_devad_i[1:0]. Any other device address gives rsp_ack_o low, rsp_rdata_o = 0, and changes no state.
- R2: After synchronous reset, register 17 of every channel reads 16'hC000 with bit 13 set to the inverse of mode_pin_i. Registers 24 and 25 read 0. Register 19 reads 16'h7F80, so err_code_o = 9'h1FE.
- R3: Through channel 0, register 2 reads 16'h0033 and register 3 reads 16'h2C31 (fields 6'h0B, 6'h03, 4'h1 from the top down). Writes to both are discarded.
- R4: Register 17 bits map to outputs as follows: 15 to tx_full_rate_o, 14 to rx_full_rate_o, 12 to comma_pos_edge_o, 11 to loopback_o, 10 to los_cdr_o. Bit 13 is the comma-alignment enable. Bits 9:0 read 0 and ignore writes.
- R5: Register 25 bit 13 and register 17 bit 11 are one loopback bit per channel. A write to either location sets it, and a read of either location returns it.
- R6: Register 24 bit 1 is the per-channel byte-align enable. comma_align_o is high only when both this bit and register 17 bit 13 are set. All other bits of registers 24 and 25 read 0.
- R7: Register 19 bits 14:6 hold the shared error code, which drives err_code_o. Bit 15 and bits 5:0 read 0 and ignore writes.
- R8: Registers 2, 3 and 19 accessed through channels 1 to 3 are acknowledged, read 0, and writes to them change nothing.
- R9: Register addresses other than 2, 3, 17, 19, 24 and 25 are acknowledged, read 0, and writes to them change nothing.
- R10: The response appears in the cycle after the request and lasts one cycle. A write's effect is visible on the outputs in that same cycle, and a write returns rdata 0.
- R11: A write to one channel changes no other channel's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pin_i | input | 1 | Mode pin; its inverse is the reset value of the comma-alignment enable |
| strap_i | input | 3 | Upper device-address bits |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_devad_i | input | 5 | Device address |
| req_regad_i | input | 5 | Register address |
| req_wdata_i | input | 16 | Write data |
| rsp_ack_o | output | 1 | Response acknowledge |
| rsp_rdata_o | output | 16 | Registered read data |
| tx_full_rate_o | output | 4 | Per-channel transmit full rate |
| rx_full_rate_o | output | 4 | Per-channel receive full rate |
| comma_align_o | output | 4 | Per-channel effective comma-alignment enable |
| comma_pos_edge_o | output | 4 | Per-channel comma edge, 1 = rising |
| loopback_o | output | 4 | Per-channel internal loopback |
| los_cdr_o | output | 4 | Per-channel: include CDR lock loss in LOS |
| err_code_o | output | 9 | Shared error code |

## Verification
Any bad configuration bit appears on a control output in the cycle after the write that caused it. A bad read path appears in the acknowledged response one cycle after the read. A decode error shows up as one of three symptoms: a missing acknowledge, an acknowledge outside the window, or an output changing on another channel. For this reason, every write is followed by a read-back and a check of that channel's and its neighbours' outputs. Because the loopback bit is shared between two addresses, a split into two storage bits is caught by a write through one location and a read through the other.

// File: rtl/mgmt_regbank_pkg.sv
package mgmt_regbank_pkg;
    localparam int DATA_W = 16;
    localparam int REGA_W = 5;
    localparam int ERR_W  = 9;

    localparam logic [REGA_W-1:0] RA_ID_HI = 5'd2;
    localparam logic [REGA_W-1:0] RA_ID_LO = 5'd3;
    localparam logic [REGA_W-1:0] RA_CFG   = 5'd17;
    localparam logic [REGA_W-1:0] RA_ERR   = 5'd19;
    localparam logic [REGA_W-1:0] RA_ALIGN = 5'd24;
    localparam logic [REGA_W-1:0] RA_TEST  = 5'd25;

    localparam logic [DATA_W-1:0] ID_HI_VAL = 16'h0033;
    localparam logic [DATA_W-1:0] ID_LO_VAL = {6'h0B, 6'h03, 4'h1};
    localparam logic [ERR_W-1:0]  ERR_RST   = 9'h1FE;

    localparam int ERR_LSB = 6;

    typedef struct packed {
        logic tx_full;
        logic rx_full;
        logic comma_en;
        logic comma_rise;
        logic loopback;
        logic cdr_in_los;
        logic byte_align;
    } chan_cfg_t;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/mrb_chan.sv
module mrb_chan
    import mgmt_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin_i,
    input  logic              wr_en_i,
    input  logic [REGA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output chan_cfg_t         cfg_o
);
    chan_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.tx_full    = 1'b1;
            cfg_d.rx_full    = 1'b1;
            cfg_d.comma_en   = ~mode_pin_i;
            cfg_d.comma_rise = 1'b0;
            cfg_d.loopback   = 1'b0;
            cfg_d.cdr_in_los = 1'b0;
            cfg_d.byte_align = 1'b0;
        end else if (wr_en_i) begin
            case (reg_i)
                RA_CFG: begin
                    cfg_d.tx_full    = wdata_i[15];
                    cfg_d.rx_full    = wdata_i[14];
                    cfg_d.comma_en   = wdata_i[13];
                    cfg_d.comma_rise = wdata_i[12];
                    cfg_d.loopback   = wdata_i[11];
                    cfg_d.cdr_in_los = wdata_i[10];
                end
                RA_ALIGN: cfg_d.byte_align = wdata_i[1];
                RA_TEST:  cfg_d.loopback   = wdata_i[13];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    always_comb begin
        case (reg_i)
            RA_CFG:   rdata_o = {cfg_q.tx_full, cfg_q.rx_full, cfg_q.comma_en,
                                 cfg_q.comma_rise, cfg_q.loopback, cfg_q.cdr_in_los, 10'h000};
            RA_ALIGN: rdata_o = {14'h0000, cfg_q.byte_align, 1'b0};
            RA_TEST:  rdata_o = {2'b00, cfg_q.loopback, 13'h0000};
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    // R5: loopback moves only on a write to one of its two locations
    assert_loopback_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (reg_i == RA_CFG || reg_i == RA_TEST)) |=> $stable(cfg_q.loopback));

    // R4: rate bits move only on a write to the config register
    assert_rate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && reg_i == RA_CFG) |=> $stable({cfg_q.tx_full, cfg_q.rx_full}));

    // R6: byte-align moves only on a write to its register
    assert_align_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && reg_i == RA_ALIGN) |=> $stable(cfg_q.byte_align));
endmodule

// File: rtl/mrb_shared.sv
module mrb_shared
    import mgmt_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REGA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ERR_W-1:0]  err_code_o
);
    logic [ERR_W-1:0] err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (!rst_n)
            err_d = ERR_RST;
        else if (wr_en_i && reg_i == RA_ERR)
            err_d = wdata_i[ERR_LSB +: ERR_W];
    end

    always_ff @(posedge clk) begin
        err_q <= err_d;
    end

    always_comb begin
        case (reg_i)
            RA_ID_HI: rdata_o = ID_HI_VAL;
            RA_ID_LO: rdata_o = ID_LO_VAL;
            RA_ERR:   rdata_o = {1'b0, err_q, 6'h00};
            default:  rdata_o = '0;
        endcase
    end

    assign err_code_o = err_q;

    // R7: error code held unless written through channel 0
    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && reg_i == RA_ERR) |=> $stable(err_q));
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
    import mgmt_regbank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 5,
    localparam int CH_W    = $clog2(NCH),
    localparam int STRAP_W = ADDR_W - CH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_pin_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_devad_i,
    input  logic [REGA_W-1:0]  req_regad_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    output logic               rsp_ack_o,
    output logic [DATA_W-1:0]  rsp_rdata_o,
    output logic [NCH-1:0]     tx_full_rate_o,
    output logic [NCH-1:0]     rx_full_rate_o,
    output logic [NCH-1:0]     comma_align_o,
    output logic [NCH-1:0]     comma_pos_edge_o,
    output logic [NCH-1:0]     loopback_o,
    output logic [NCH-1:0]     los_cdr_o,
    output logic [ERR_W-1:0]   err_code_o
);
    logic            hit;
    logic [CH_W-1:0] ch;
    logic            is_shared;
    logic            wr_req;
    logic [DATA_W-1:0] chan_rdata [NCH];
    logic [DATA_W-1:0] shared_rdata;
    rsp_t rsp_d, rsp_q;
    logic started_q;

    assign hit       = req_valid_i && (req_devad_i[ADDR_W-1:CH_W] == strap_i);
    assign ch        = req_devad_i[CH_W-1:0];
    assign is_shared = (req_regad_i == RA_ID_HI) || (req_regad_i == RA_ID_LO) ||
                       (req_regad_i == RA_ERR);
    assign wr_req    = hit && req_write_i;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            chan_cfg_t cfg;
            logic      wr_en;
            assign wr_en = wr_req && !is_shared && (ch == CH_W'(i));
            mrb_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .mode_pin_i (mode_pin_i),
                .wr_en_i    (wr_en),
                .reg_i      (req_regad_i),
                .wdata_i    (req_wdata_i),
                .rdata_o    (chan_rdata[i]),
                .cfg_o      (cfg)
            );
            assign tx_full_rate_o[i]   = cfg.tx_full;
            assign rx_full_rate_o[i]   = cfg.rx_full;
            assign comma_align_o[i]    = cfg.comma_en & cfg.byte_align;
            assign comma_pos_edge_o[i] = cfg.comma_rise;
            assign loopback_o[i]       = cfg.loopback;
            assign los_cdr_o[i]        = cfg.cdr_in_los;
        end
    endgenerate

    mrb_shared u_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_req && is_shared && (ch == '0)),
        .reg_i      (req_regad_i),
        .wdata_i    (req_wdata_i),
        .rdata_o    (shared_rdata),
        .err_code_o (err_code_o)
    );

    always_comb begin
        rsp_d = '0;
        if (rst_n && hit) begin
            rsp_d.ack = 1'b1;
            if (!req_write_i) begin
                if (is_shared)
                    rsp_d.rdata = (ch == '0) ? shared_rdata : '0;
                else
                    rsp_d.rdata = chan_rdata[ch];
            end
        end
    end

    always_ff @(posedge clk) begin
        rsp_q     <= rsp_d;
        started_q <= rst_n;
    end

    assign rsp_ack_o   = rsp_q.ack;
    assign rsp_rdata_o = rsp_q.rdata;

    // R1: acknowledge follows exactly an in-window request one cycle earlier
    assert_ack_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (rsp_ack_o == $past(req_valid_i &&
                        req_devad_i[ADDR_W-1:CH_W] == strap_i)));

    // R10: an ack never lasts two cycles without a second request
    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && rsp_ack_o && !$past(req_valid_i, 1)) |-> 1'b0);

    // R3: identification word through channel 0
    assert_id_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !req_write_i && ch == '0 && req_regad_i == RA_ID_HI) |=>
        (rsp_rdata_o == 16'h0033));

    // R8: shared registers through other channels read zero
    assert_shared_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !req_write_i && ch != '0 && is_shared) |=> (rsp_rdata_o == '0));
endmodule

// File: tb/mgmt_regbank_test.sv
module mgmt_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_pin;
    logic [2:0]  strap;
    logic        valid, write;
    logic [4:0]  devad, regad;
    logic [15:0] wdata;
    logic        ack;
    logic [15:0] rdata;
    logic [3:0]  tx_fr, rx_fr, c_al, c_pos, lpbk, los;
    logic [8:0]  errc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mgmt_regbank uut (
        .clk(clk), .rst_n(rst_n), .mode_pin_i(mode_pin), .strap_i(strap),
        .req_valid_i(valid), .req_write_i(write), .req_devad_i(devad),
        .req_regad_i(regad), .req_wdata_i(wdata), .rsp_ack_o(ack),
        .rsp_rdata_o(rdata), .tx_full_rate_o(tx_fr), .rx_full_rate_o(rx_fr),
        .comma_align_o(c_al), .comma_pos_edge_o(c_pos), .loopback_o(lpbk),
        .los_cdr_o(los), .err_code_o(errc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request; response sampled at the following falling edge
    task automatic xact(input logic wr, input logic [4:0] dv, input logic [4:0] ra,
                        input logic [15:0] wd, output logic a, output logic [15:0] rd);
        @(negedge clk);
        valid = 1'b1; write = wr; devad = dv; regad = ra; wdata = wd;
        @(negedge clk);
        a = ack; rd = rdata;
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic do_reset(input logic mp);
        @(negedge clk);
        mode_pin = mp; rst_n = 1'b0; valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic a; logic [15:0] rd;
        check("R2 tx rate", {28'h0, tx_fr}, 32'hF);
        check("R2 rx rate", {28'h0, rx_fr}, 32'hF);
        check("R2 loopback", {28'h0, lpbk}, 32'h0);
        check("R2 comma_align", {28'h0, c_al}, 32'h0);
        check("R2 err_code", {23'h0, errc}, 32'h1FE);
        xact(1'b0, 5'h14, 5'd17, 16'h0, a, rd);
        check("R2 reg17 ch0 mode0", {16'h0, rd}, 32'hE000);
        xact(1'b0, 5'h17, 5'd24, 16'h0, a, rd);
        check("R2 reg24 ch3", {16'h0, rd}, 32'h0);
        xact(1'b0, 5'h14, 5'd19, 16'h0, a, rd);
        check("R2 reg19", {16'h0, rd}, 32'h7F80);
    endtask

    task automatic t_window();
        logic a; logic [15:0] rd;
        xact(1'b0, 5'h14, 5'd17, 16'h0, a, rd);
        check("R1 in-window ack", {31'h0, a}, 32'h1);
        xact(1'b0, 5'h13, 5'd17, 16'h0, a, rd);
        check("R1 below window ack", {31'h0, a}, 32'h0);
        check("R1 below window rdata", {16'h0, rd}, 32'h0);
        xact(1'b1, 5'h18, 5'd17, 16'h0000, a, rd);
        check("R1 above window ack", {31'h0, a}, 32'h0);
        check("R1 out-of-window write ignored", {28'h0, tx_fr}, 32'hF);
    endtask

    task automatic t_timing();
        logic a; logic [15:0] rd;
        @(negedge clk);
        valid = 1'b1; write = 1'b0; devad = 5'h14; regad = 5'd2;
        #2;
        check("R10 no ack before edge", {31'h0, ack}, 32'h0);
        @(negedge clk);
        valid = 1'b0;
        check("R10 ack after edge", {31'h0, ack}, 32'h1);
        @(negedge clk);
        check("R10 ack one cycle only", {31'h0, ack}, 32'h0);
        xact(1'b1, 5'h14, 5'd17, 16'hE000, a, rd);
        check("R10 write rdata zero", {16'h0, rd}, 32'h0);
    endtask

    task automatic t_id();
        logic a; logic [15:0] rd;
        xact(1'b0, 5'h14, 5'd2, 16'h0, a, rd);
        check("R3 reg2", {16'h0, rd}, 32'h0033);
        xact(1'b0, 5'h14, 5'd3, 16'h0, a, rd);
        check("R3 reg3", {16'h0, rd}, 32'h2C31);
        xact(1'b1, 5'h14, 5'd3, 16'h0000, a, rd);
        xact(1'b0, 5'h14, 5'd3, 16'h0, a, rd);
        check("R3 reg3 write discarded", {16'h0, rd}, 32'h2C31);
    endtask

    task automatic t_cfg();
        logic a; logic [15:0] rd;
        xact(1'b1, 5'h15, 5'd17, 16'h3FFF, a, rd);
        check("R4 tx ch1", {28'h0, tx_fr}, 32'hD);
        check("R4 rx ch1", {28'h0, rx_fr}, 32'hD);
        check("R4 pos edge ch1", {28'h0, c_pos}, 32'h2);
        check("R4 loopback ch1", {28'h0, lpbk}, 32'h2);
        check("R4 los ch1", {28'h0, los}, 32'h2);
        check("R11 comma align no byte align", {28'h0, c_al}, 32'h0);
        xact(1'b0, 5'h15, 5'd17, 16'h0, a, rd);
        check("R4 reg17 ch1 readback", {16'h0, rd}, 32'h3C00);
        xact(1'b0, 5'h14, 5'd17, 16'h0, a, rd);
        check("R11 ch0 untouched", {16'h0, rd}, 32'hE000);
    endtask

    task automatic t_alias();
        logic a; logic [15:0] rd;
        xact(1'b1, 5'h16, 5'd25, 16'h2000, a, rd);
        check("R5 loopback via reg25", {28'h0, lpbk}, 32'h6);
        xact(1'b0, 5'h16, 5'd17, 16'h0, a, rd);
        check("R5 reg17 shows alias", {16'h0, rd}, 32'hE800);
        xact(1'b1, 5'h16, 5'd17, 16'hE000, a, rd);
        xact(1'b0, 5'h16, 5'd25, 16'h0, a, rd);
        check("R5 reg25 cleared via reg17", {16'h0, rd}, 32'h0);
        check("R5 loopback ch2 off", {28'h0, lpbk}, 32'h2);
    endtask

    task automatic t_align();
        logic a; logic [15:0] rd;
        xact(1'b1, 5'h17, 5'd24, 16'hFFFF, a, rd);
        check("R6 comma align ch3 on", {28'h0, c_al}, 32'h8);
        xact(1'b0, 5'h17, 5'd24, 16'h0, a, rd);
        check("R6 reg24 readback", {16'h0, rd}, 32'h0002);
        xact(1'b1, 5'h17, 5'd17, 16'hC000, a, rd);
        check("R6 comma align needs enable", {28'h0, c_al}, 32'h0);
        xact(1'b1, 5'h17, 5'd25, 16'hDFFF, a, rd);
        xact(1'b0, 5'h17, 5'd25, 16'h0, a, rd);
        check("R6 reg25 other bits zero", {16'h0, rd}, 32'h0);
    endtask

    task automatic t_err();
        logic a; logic [15:0] rd;
        xact(1'b1, 5'h14, 5'd19, 16'hFFFF, a, rd);
        check("R7 err_code all ones", {23'h0, errc}, 32'h1FF);
        xact(1'b0, 5'h14, 5'd19, 16'h0, a, rd);
        check("R7 reg19 reserved zero", {16'h0, rd}, 32'h7FC0);
        xact(1'b1, 5'h14, 5'd19, 16'hAAFF, a, rd);
        check("R7 err_code pattern", {23'h0, errc}, 32'h0AB);
        xact(1'b0, 5'h14, 5'd19, 16'h0, a, rd);
        check("R7 reg19 pattern", {16'h0, rd}, 32'h2AC0);
    endtask

    task automatic t_shared_other();
        logic a; logic [15:0] rd;
        xact(1'b1, 5'h15, 5'd19, 16'h0000, a, rd);
        check("R8 write via ch1 acked", {31'h0, a}, 32'h1);
        check("R8 write via ch1 ignored", {23'h0, errc}, 32'h0AB);
        xact(1'b0, 5'h15, 5'd2, 16'h0, a, rd);
        check("R8 reg2 via ch1", {16'h0, rd}, 32'h0);
        xact(1'b0, 5'h16, 5'd3, 16'h0, a, rd);
        check("R8 reg3 via ch2", {16'h0, rd}, 32'h0);
        xact(1'b0, 5'h17, 5'd19, 16'h0, a, rd);
        check("R8 reg19 via ch3", {16'h0, rd}, 32'h0);
    endtask

    task automatic t_unimpl();
        logic a; logic [15:0] rd;
        xact(1'b1, 5'h14, 5'd5, 16'hFFFF, a, rd);
        check("R9 unimpl write acked", {31'h0, a}, 32'h1);
        xact(1'b0, 5'h14, 5'd5, 16'h0, a, rd);
        check("R9 unimpl reads zero", {16'h0, rd}, 32'h0);
        xact(1'b1, 5'h14, 5'd31, 16'h0000, a, rd);
        check("R9 outputs untouched", {28'h0, tx_fr}, 32'hD);
        check("R9 err untouched", {23'h0, errc}, 32'h0AB);
    endtask

    task automatic t_mode_reset();
        logic a; logic [15:0] rd;
        do_reset(1'b1);
        xact(1'b0, 5'h14, 5'd17, 16'h0, a, rd);
        check("R2 reg17 ch0 mode1", {16'h0, rd}, 32'hC000);
        check("R2 err after reset", {23'h0, errc}, 32'h1FE);
        check("R2 loopback after reset", {28'h0, lpbk}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; mode_pin = 1'b0; strap = 3'b101;
        valid = 1'b0; write = 1'b0; devad = '0; regad = '0; wdata = '0;
        do_reset(1'b0);
        t_reset();
        t_window();
        t_timing();
        t_id();
        t_cfg();
        t_alias();
        t_align();
        t_err();
        t_shared_other();
        t_unimpl();
        t_mode_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule